// File: doc/BRIEF.md
# Compare-Clear Timer/Counter

This block is an up-counter that advances by one on each cycle in which its prescaled tick enable is high. It has three modes of counting. In the narrow free-running mode only the low half of the counter counts, and it wraps from all ones to zero. In the wide free-running mode the full count wraps the same way. In compare-clear mode the low half returns to zero on the tick after it equals the low half of a compare register, so the compare value sets the period.

The block raises a pulse on a compare match. It keeps two sticky flags, one for overflow and one for compare matches. Each flag has a clear input, which the surrounding logic drives when an interrupt is acknowledged. The counter and the compare register can both be written at any time through plain write ports.

The compare register is not double-buffered. If the compare value is lowered below the running count in compare-clear mode, the counter misses the match. It then counts up to the top of the low half, wraps to zero, and only then reaches the new compare value.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the count is 0, the compare register is 0, both flags are 0 and the match pulse is 0.
- R2: The count changes only on a cycle with `tick_en` high or `cnt_wr_en` high. A tick without a write adds one to the count, and the new value is visible in the next cycle.
- R3: A counter write loads `cnt_wr_data` in the next cycle and takes priority over a tick in the same cycle. A write cycle sets neither flag and gives no match pulse.
- R4: The mode is selected by `mode_sel`: 0 is narrow free-running, 1 is wide free-running, 2 is compare-clear, and 3 behaves as 0. In modes 0, 2 and 3 only the low 8 bits count and the high 8 bits hold. A tick with the low byte at 0xFF takes the low byte to 0x00 and sets the overflow flag.
- R5: In mode 1, a tick at 0xFFFF takes the count to 0x0000 and sets the overflow flag. A carry from the low byte into the high byte (for example 0x00FF to 0x0100) does not set the overflow flag.
- R6: The overflow flag stays set until a cycle with `ovf_clr` high clears it. If `ovf_clr` is high in the same cycle as a new overflow, the flag ends up set.
- R7: In mode 2, a tick with the low byte equal to the low byte of the compare register takes the low byte to 0x00, sets the compare flag, and raises `cmpa_match` for exactly the next cycle.
- R8: A compare write takes effect from the following cycle, with no buffering. In mode 2, if the new compare value is below the current count, no match occurs until the low byte has counted to 0xFF and wrapped to 0x00.
- R9: In mode 1, a tick with the full count equal to the compare register sets the compare flag and pulses `cmpa_match`, and the count still increments. In modes 0 and 3 the same happens on equality of the low bytes.
- R10: The compare flag stays set until a cycle with `cmpa_clr` high clears it. If `cmpa_clr` is high in the same cycle as a new match, the flag ends up set.
- R11: In mode 2, the overflow flag is still set on the tick that takes the low byte from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable |
| mode_sel | input | 2 | Mode: 0 narrow, 1 wide, 2 compare-clear, 3 as 0 |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_data | input | 16 | Counter write value |
| cmp_wr_en | input | 1 | Compare register write strobe |
| cmp_wr_data | input | 16 | Compare register write value |
| ovf_clr | input | 1 | Overflow flag clear (acknowledge) |
| cmpa_clr | input | 1 | Compare flag clear (acknowledge) |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmpa_flag | output | 1 | Sticky compare flag |
| cmpa_match | output | 1 | One-cycle compare match pulse |

## Verification
The counter value is visible at `count` in every cycle. A wrong increment, a missed load, or a clear on the wrong match therefore shows up one cycle after the tick that caused it. A wrong internal compare value cannot be seen directly. It shows up later, as a match pulse and compare flag that arrive in the wrong cycle, or as a compare-clear period of the wrong length. For this reason the random phase keeps compare values small in compare-clear mode, so that many full periods run. A wrong flag merge or clear priority is seen the cycle after a set and a clear coincide.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic [1:0] {
    MODE_FREE8  = 2'd0,
    MODE_FREE16 = 2'd1,
    MODE_CTC    = 2'd2,
    MODE_SPARE  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wide_mode,
  input  logic             clr_mode,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             hit,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt,
  output logic             match_evt
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0]  ONE_F = CNT_W'(1);
  localparam logic [HALF_W-1:0] ONE_H = HALF_W'(1);

  logic             step;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  // next-state logic
  always_comb begin
    step      = tick_en & ~wr_en;
    wrap_evt  = step & (wide_mode ? (&cnt_q) : (&cnt_q[HALF_W-1:0]));
    match_evt = step & hit;
    cnt_en    = wr_en | step;
    cnt_d     = cnt_q;
    if (wr_en) begin
      cnt_d = wr_data;
    end else if (wide_mode) begin
      cnt_d = cnt_q + ONE_F;
    end else if (clr_mode && hit) begin
      cnt_d[HALF_W-1:0] = '0;
    end else begin
      cnt_d[HALF_W-1:0] = cnt_q[HALF_W-1:0] + ONE_H;
    end
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] count,
  input  logic             wide_mode,
  output logic             hit
);
  localparam int HALF_W = CNT_W / 2;
  localparam int N_HALF = 2;

  logic [CNT_W-1:0]  cmp_d;
  logic [CNT_W-1:0]  cmp_q;
  logic [N_HALF-1:0] half_eq;

  always_comb begin
    cmp_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_en) begin
      cmp_q <= cmp_d;
    end
  end

  // one equality comparator per counter half
  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign half_eq[h] = (count[h*HALF_W +: HALF_W] == cmp_q[h*HALF_W +: HALF_W]);
  end

  assign hit = wide_mode ? (&half_eq) : half_eq[0];
endmodule

// File: rtl/cmp_timer_flag.sv
module cmp_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d;
  logic flag_q;

  // set takes priority over an acknowledge in the same cycle
  always_comb begin
    flag_d = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [1:0]       mode_sel,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             ovf_clr,
  input  logic             cmpa_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             cmpa_flag,
  output logic             cmpa_match
);
  tmr_mode_e mode;
  logic      wide_mode;
  logic      clr_mode;
  logic      hit;
  logic      wrap_evt;
  logic      match_evt;
  logic      pulse_d;
  logic      pulse_q;

  always_comb begin
    mode      = tmr_mode_e'(mode_sel);
    wide_mode = (mode == MODE_FREE16);
    clr_mode  = (mode == MODE_CTC);
  end

  cmp_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wide_mode (wide_mode),
    .clr_mode  (clr_mode),
    .wr_en     (cnt_wr_en),
    .wr_data   (cnt_wr_data),
    .hit       (hit),
    .count     (count),
    .wrap_evt  (wrap_evt),
    .match_evt (match_evt)
  );

  cmp_timer_match #(.CNT_W(CNT_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cmp_wr_en),
    .wr_data   (cmp_wr_data),
    .count     (count),
    .wide_mode (wide_mode),
    .hit       (hit)
  );

  cmp_timer_flag u_ovf (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wrap_evt),
    .clr   (ovf_clr),
    .flag  (ovf_flag)
  );

  cmp_timer_flag u_cmpa (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (match_evt),
    .clr   (cmpa_clr),
    .flag  (cmpa_flag)
  );

  always_comb begin
    pulse_d = match_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign cmpa_match = pulse_q;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [1:0]       mode_sel,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic             cmp_wr_en,
  input logic [CNT_W-1:0] cmp_wr_data,
  input logic             ovf_clr,
  input logic             cmpa_clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             cmpa_flag,
  input logic             cmpa_match
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE_F = CNT_W'(1);

  logic [CNT_W-1:0] cmp_sh;
  logic             stp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_sh <= '0;
    end else if (cmp_wr_en) begin
      cmp_sh <= cmp_wr_data;
    end
  end

  assign stp = tick_en & ~cnt_wr_en;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr_en) |=> $stable(count)); // R2
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (count == $past(cnt_wr_data))); // R3
  AST_WRITE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_en && !ovf_flag) |=> !ovf_flag); // R3
  AST_NARROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'd1 && stp && (&count[HALF_W-1:0])) |=> (count[HALF_W-1:0] == '0 && ovf_flag)); // R4
  AST_WIDE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd1 && stp && (&count)) |=> (count == '0 && ovf_flag)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R6
  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd2 && stp && count[HALF_W-1:0] == cmp_sh[HALF_W-1:0]) |=> (count[HALF_W-1:0] == '0 && cmpa_match)); // R7
  AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmpa_match |-> cmpa_flag); // R7
  AST_WIDE_NOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd1 && stp && !(&count)) |=> (count == $past(count) + ONE_F)); // R9
  AST_CMPA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpa_flag && !cmpa_clr) |=> cmpa_flag); // R10
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .mode_sel    (mode_sel),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .cmp_wr_en   (cmp_wr_en),
  .cmp_wr_data (cmp_wr_data),
  .ovf_clr     (ovf_clr),
  .cmpa_clr    (cmpa_clr),
  .count       (count),
  .ovf_flag    (ovf_flag),
  .cmpa_flag   (cmpa_flag),
  .cmpa_match  (cmpa_match)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        cnt_wr_en = 1'b0;
  logic [15:0] cnt_wr_data = '0;
  logic        cmp_wr_en = 1'b0;
  logic [15:0] cmp_wr_data = '0;
  logic        ovf_clr = 1'b0;
  logic        cmpa_clr = 1'b0;
  logic [15:0] count;
  logic        ovf_flag;
  logic        cmpa_flag;
  logic        cmpa_match;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] m_cnt = '0;
  logic [15:0] m_cmp = '0;
  logic        m_ovf = 1'b0;
  logic        m_cmf = 1'b0;
  logic        m_pul = 1'b0;

  always #2 clk = ~clk;

  cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .ovf_clr(ovf_clr), .cmpa_clr(cmpa_clr),
    .count(count), .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag), .cmpa_match(cmpa_match)
  );

  function automatic bit f_hit(input logic [15:0] c, input logic [15:0] k, input logic [1:0] m);
    return (m == 2'd1) ? (c == k) : (c[7:0] == k[7:0]);
  endfunction

  function automatic bit f_wrap(input logic [15:0] c, input logic [1:0] m);
    return (m == 2'd1) ? (c == 16'hFFFF) : (c[7:0] == 8'hFF);
  endfunction

  function automatic logic [15:0] f_next(input logic [15:0] c, input logic [15:0] k,
                                         input logic [1:0] m);
    if (m == 2'd1) return c + 16'd1;
    if (m == 2'd2 && c[7:0] == k[7:0]) return {c[15:8], 8'h00};
    return {c[15:8], c[7:0] + 8'd1};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input bit t, input logic [1:0] m,
                      input bit cw, input logic [15:0] cwd,
                      input bit kw, input logic [15:0] kwd,
                      input bit oc, input bit cc);
    bit s, w, h;
    @(negedge clk);
    tick_en = t; mode_sel = m; cnt_wr_en = cw; cnt_wr_data = cwd;
    cmp_wr_en = kw; cmp_wr_data = kwd; ovf_clr = oc; cmpa_clr = cc;
    s = t && !cw;
    w = s && f_wrap(m_cnt, m);
    h = s && f_hit(m_cnt, m_cmp, m);
    @(posedge clk);
    if (cw) m_cnt = cwd;
    else if (s) m_cnt = f_next(m_cnt, m_cmp, m);
    if (kw) m_cmp = kwd;
    m_ovf = w | (m_ovf & ~oc);
    m_cmf = h | (m_cmf & ~cc);
    m_pul = h;
    #1;
    chk(req, "count", count, m_cnt);
    chk(req, "ovf_flag", {15'd0, ovf_flag}, {15'd0, m_ovf});
    chk(req, "cmpa_flag", {15'd0, cmpa_flag}, {15'd0, m_cmf});
    chk(req, "cmpa_match", {15'd0, cmpa_match}, {15'd0, m_pul});
  endtask

  task automatic tk(input string req, input logic [1:0] m);
    step(req, 1'b1, m, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1", "count", count, 16'h0000);
    chk("R1", "ovf_flag", {15'd0, ovf_flag}, 16'd0);
    chk("R1", "cmpa_flag", {15'd0, cmpa_flag}, 16'd0);
    chk("R1", "cmpa_match", {15'd0, cmpa_match}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: no tick, no change; then two ticks (also a low-byte match with reset compare 0)
    repeat (3) step("R2", 1'b0, 2'd0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    chk("R2", "count idle", count, 16'h0000);
    tk("R2", 2'd0);
    tk("R2", 2'd0);
    chk("R2", "count after 2 ticks", count, 16'h0002);
    chk("R1", "reset compare 0 matched", {15'd0, cmpa_flag}, 16'd1);
    step("R10", 1'b0, 2'd0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
    chk("R10", "cmpa cleared", {15'd0, cmpa_flag}, 16'd0);

    // R3: write beats tick, no flag
    step("R3", 1'b1, 2'd0, 1'b1, 16'h12FF, 1'b0, '0, 1'b0, 1'b0);
    chk("R3", "loaded", count, 16'h12FF);
    chk("R3", "no ovf on write", {15'd0, ovf_flag}, 16'd0);

    // R4: low byte wrap, high byte holds
    tk("R4", 2'd3);
    chk("R4", "wrap", count, 16'h1200);
    chk("R4", "ovf set", {15'd0, ovf_flag}, 16'd1);

    // R6: clear, then set wins over clear
    step("R6", 1'b0, 2'd0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    chk("R6", "ovf cleared", {15'd0, ovf_flag}, 16'd0);
    step("R6", 1'b0, 2'd0, 1'b1, 16'h00FF, 1'b0, '0, 1'b0, 1'b0);
    step("R6", 1'b1, 2'd0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    chk("R6", "set wins", {15'd0, ovf_flag}, 16'd1);
    step("R6", 1'b0, 2'd0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b1);

    // R5: wide mode carries without flag, wraps with flag
    step("R5", 1'b0, 2'd1, 1'b1, 16'h00FF, 1'b1, 16'h8000, 1'b0, 1'b0);
    tk("R5", 2'd1);
    chk("R5", "carry", count, 16'h0100);
    chk("R5", "no ovf on carry", {15'd0, ovf_flag}, 16'd0);
    step("R5", 1'b0, 2'd1, 1'b1, 16'hFFFF, 1'b0, '0, 1'b0, 1'b0);
    tk("R5", 2'd1);
    chk("R5", "wide wrap", count, 16'h0000);
    chk("R5", "wide ovf", {15'd0, ovf_flag}, 16'd1);
    step("R5", 1'b0, 2'd1, 1'b0, '0, 1'b0, '0, 1'b1, 1'b1);

    // R7: compare-clear period of 4 ticks
    step("R7", 1'b0, 2'd2, 1'b1, 16'h0000, 1'b1, 16'h0003, 1'b0, 1'b0);
    repeat (3) tk("R7", 2'd2);
    chk("R7", "at top", count, 16'h0003);
    chk("R7", "no flag yet", {15'd0, cmpa_flag}, 16'd0);
    tk("R7", 2'd2);
    chk("R7", "cleared", count, 16'h0000);
    chk("R7", "flag", {15'd0, cmpa_flag}, 16'd1);
    chk("R7", "pulse", {15'd0, cmpa_match}, 16'd1);
    step("R7", 1'b0, 2'd2, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
    chk("R7", "pulse one cycle", {15'd0, cmpa_match}, 16'd0);

    // R8 / R11: compare lowered below count
    step("R8", 1'b0, 2'd2, 1'b1, 16'h0050, 1'b1, 16'h0010, 1'b0, 1'b0);
    for (int i = 0; i < 176; i++) tk("R8", 2'd2);
    chk("R11", "wrapped", count, 16'h0000);
    chk("R11", "ovf in ctc", {15'd0, ovf_flag}, 16'd1);
    chk("R8", "match missed", {15'd0, cmpa_flag}, 16'd0);
    for (int i = 0; i < 16; i++) tk("R8", 2'd2);
    chk("R8", "reached new top", count, 16'h0010);
    tk("R8", 2'd2);
    chk("R8", "late match", {15'd0, cmpa_flag}, 16'd1);
    chk("R8", "late clear", count, 16'h0000);
    step("R8", 1'b0, 2'd2, 1'b0, '0, 1'b0, '0, 1'b1, 1'b1);

    // R9: wide match, no clear
    step("R9", 1'b0, 2'd1, 1'b1, 16'h0233, 1'b1, 16'h0234, 1'b0, 1'b0);
    tk("R9", 2'd1);
    chk("R9", "no flag before", {15'd0, cmpa_flag}, 16'd0);
    tk("R9", 2'd1);
    chk("R9", "continues", count, 16'h0235);
    chk("R9", "flag", {15'd0, cmpa_flag}, 16'd1);
    chk("R9", "pulse", {15'd0, cmpa_match}, 16'd1);

    // R10: clear, then set wins
    step("R10", 1'b0, 2'd1, 1'b1, 16'h0240, 1'b1, 16'h0240, 1'b0, 1'b1);
    chk("R10", "cleared", {15'd0, cmpa_flag}, 16'd0);
    step("R10", 1'b1, 2'd1, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
    chk("R10", "set wins", {15'd0, cmpa_flag}, 16'd1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [1:0]  m;
      logic [15:0] kd;
      m  = 2'($urandom_range(0, 3));
      kd = 16'($urandom);
      if (m != 2'd1) kd = {kd[15:8], 4'h0, kd[3:0]};
      step("R2", ($urandom_range(0, 9) < 7), m,
           ($urandom_range(0, 19) == 0), 16'($urandom),
           ($urandom_range(0, 19) == 0), kd,
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
    end
    finish_up();
  end
endmodule